// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital sequencer for a dual-slope integrating converter with a resolution of four and a half digits. It runs on the converter clock and takes one input from the analog side: a comparator bit that is high while the integrator output sits on the positive side. It drives four one-hot phase selects for the analog switches. The phases are offset cancellation, signal integration, reference de-integration and integrator discharge, and they repeat in that order.

While the input is being integrated, the sequencer captures the sign of the input. That stored sign picks the reference polarity for the de-integration slope. De-integration stops on the first clock where the comparator shows the integrator has swung back across zero, and the count at that clock becomes the result. If no crossing arrives before a fixed cap, the result saturates and an overrange flag is raised. The discharge phase after an overranged conversion is longer than the normal one. The offset-cancellation phase takes up the remaining clocks, so every conversion frame has the same length. A busy strobe is high only while the input is integrated and de-integrated.

Top module: `dsadc_seq`

## Requirements
- R1: `phase_o` is always one-hot, with bit 0 = offset cancel, bit 1 = signal integrate, bit 2 = de-integrate and bit 3 = discharge. Phases advance only in the order bit 0, 1, 2, 3 and then back to 0.
- R2: Signal integration lasts exactly `INT_CLKS` clocks.
- R3: `pol_o` takes the value of `cmp_pos_i` on the last signal-integrate clock. It changes at no other time except reset.
- R4: De-integration ends on the first clock, counting from 0, on which `cmp_pos_i` differs from `pol_o`. `result_o` then holds that count, so de-integration lasts `result_o`+1 clocks.
- R5: If no crossing arrives within `DI_MAX` clocks, de-integration ends after `DI_MAX` clocks, `result_o` becomes `DI_MAX` and `ovr_o` is set.
- R6: `ovr_o` is updated at the end of every de-integration. An in-range conversion clears it.
- R7: Discharge lasts `ZI_NORM` clocks after an in-range conversion and `ZI_OVR` clocks after an overranged one.
- R8: Every frame, from the start of signal integration to the next such start, is exactly `CYCLE` clocks. The offset-cancel phase absorbs the variation. After reset, offset cancel lasts `CYCLE` clocks.
- R9: `busy_o` is high on exactly the signal-integrate and de-integrate clocks. It is high for `INT_CLKS` plus the de-integrate length per frame.
- R10: During discharge and offset cancel, `cmp_pos_i` has no effect on `result_o`, `pol_o`, `ovr_o` or phase timing.
- R11: A synchronous active-high `rst_i` forces offset cancel and clears `result_o`, `pol_o` and `ovr_o` on the next clock, from any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmp_pos_i | input | 1 | Comparator, 1 = integrator output positive |
| phase_o | output | 4 | One-hot phase select for the analog switches |
| busy_o | output | 1 | High during signal integrate and de-integrate |
| pol_o | output | 1 | Latched input sign, selects the reference polarity |
| result_o | output | $clog2(DI_MAX+1) | De-integrate count of the last conversion |
| ovr_o | output | 1 | Last conversion hit the de-integrate cap |

## Verification
The assertions rely on the parameters leaving a positive offset-cancel pad, that is `CYCLE` greater than `INT_CLKS + DI_MAX + ZI_OVR`. They also rely on the comparator being a plain synchronous bit. The bench uses small parameter values that meet this bound. Its comparator model holds the chosen input sign through signal integration and flips it after a chosen number of de-integrate clocks, or never flips it for an overrange. It toggles the comparator freely during discharge and offset cancel, where it must be ignored.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        PH_AZ = 2'd0,
        PH_SI = 2'd1,
        PH_DI = 2'd2,
        PH_ZI = 2'd3
    } phase_e;

    localparam int NUM_PHASES = 4;
endpackage

// File: rtl/dsadc_seq_core.sv
module dsadc_seq_core
    import dsadc_pkg::*;
#(
    parameter int INT_CLKS = 10000,
    parameter int DI_MAX   = 20001,
    parameter int ZI_NORM  = 200,
    parameter int ZI_OVR   = 6200,
    parameter int CYCLE    = 40000,
    localparam int CW      = $clog2(CYCLE),
    localparam int RW      = $clog2(DI_MAX + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          cmp_pos_i,
    output phase_e        phase_o,
    output logic          pol_o,
    output logic [RW-1:0] result_o,
    output logic          ovr_o
);
    localparam logic [CW-1:0] CYC_LAST     = CW'(CYCLE - 1);
    localparam logic [CW-1:0] SI_LAST      = CW'(INT_CLKS - 1);
    localparam logic [CW-1:0] DI_LAST      = CW'(DI_MAX - 1);
    localparam logic [CW-1:0] ZN_LAST      = CW'(ZI_NORM - 1);
    localparam logic [CW-1:0] ZO_LAST      = CW'(ZI_OVR - 1);
    localparam logic [CW-1:0] CNT_ONE      = CW'(1);
    localparam logic [RW-1:0] RES_FULL     = RW'(DI_MAX);

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cyc;
        logic [CW-1:0]   cnt;
        logic            pol;
        logic [RW-1:0]   res;
        logic            ovr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [CW-1:0] zi_last;

    always_comb begin
        st_d     = st_q;
        zi_last  = st_q.ovr ? ZO_LAST : ZN_LAST;
        // frame counter wraps so the signal-integrate start is always cyc 0
        st_d.cyc = (st_q.cyc == CYC_LAST) ? '0 : st_q.cyc + CNT_ONE;
        st_d.cnt = st_q.cnt + CNT_ONE;
        unique case (st_q.ph)
            PH_AZ: begin
                st_d.cnt = '0;
                if (st_q.cyc == CYC_LAST) begin
                    st_d.ph = PH_SI;
                end
            end
            PH_SI: begin
                if (st_q.cnt == SI_LAST) begin
                    st_d.pol = cmp_pos_i;
                    st_d.ph  = PH_DI;
                    st_d.cnt = '0;
                end
            end
            PH_DI: begin
                if (cmp_pos_i != st_q.pol) begin
                    st_d.res = RW'(st_q.cnt);
                    st_d.ovr = 1'b0;
                    st_d.ph  = PH_ZI;
                    st_d.cnt = '0;
                end else if (st_q.cnt == DI_LAST) begin
                    st_d.res = RES_FULL;
                    st_d.ovr = 1'b1;
                    st_d.ph  = PH_ZI;
                    st_d.cnt = '0;
                end
            end
            PH_ZI: begin
                if (st_q.cnt == zi_last) begin
                    st_d.ph  = PH_AZ;
                    st_d.cnt = '0;
                end
            end
            default: st_d.ph = PH_AZ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.ph;
    assign pol_o    = st_q.pol;
    assign result_o = st_q.res;
    assign ovr_o    = st_q.ovr;
endmodule

// File: rtl/dsadc_phase_dec.sv
module dsadc_phase_dec
    import dsadc_pkg::*;
(
    input  phase_e                  phase_i,
    output logic [NUM_PHASES-1:0]   sel_o
);
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_sel
        assign sel_o[g] = (phase_i == phase_e'(g));
    end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
    parameter int INT_CLKS = 10000,
    parameter int DI_MAX   = 20001,
    parameter int ZI_NORM  = 200,
    parameter int ZI_OVR   = 6200,
    parameter int CYCLE    = 40000
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          cmp_pos_i,
    output logic [3:0]                    phase_o,
    output logic                          busy_o,
    output logic                          pol_o,
    output logic [$clog2(DI_MAX+1)-1:0]   result_o,
    output logic                          ovr_o
);
    import dsadc_pkg::*;

    phase_e ph;

    dsadc_seq_core #(
        .INT_CLKS (INT_CLKS),
        .DI_MAX   (DI_MAX),
        .ZI_NORM  (ZI_NORM),
        .ZI_OVR   (ZI_OVR),
        .CYCLE    (CYCLE)
    ) u_core (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cmp_pos_i (cmp_pos_i),
        .phase_o   (ph),
        .pol_o     (pol_o),
        .result_o  (result_o),
        .ovr_o     (ovr_o)
    );

    dsadc_phase_dec u_dec (
        .phase_i (ph),
        .sel_o   (phase_o)
    );

    assign busy_o = phase_o[1] | phase_o[2];
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
    parameter int INT_CLKS = 10000,
    parameter int DI_MAX   = 20001,
    parameter int ZI_NORM  = 200,
    parameter int ZI_OVR   = 6200,
    parameter int CYCLE    = 40000
) (
    input logic                         clk_i,
    input logic                         rst_i,
    input logic [3:0]                   phase_o,
    input logic                         busy_o,
    input logic                         pol_o,
    input logic [$clog2(DI_MAX+1)-1:0]  result_o,
    input logic                         ovr_o
);
    logic [31:0] si_len, di_len, zi_len, frm_len;
    logic        si_seen;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            si_len  <= '0;
            di_len  <= '0;
            zi_len  <= '0;
            frm_len <= '0;
            si_seen <= 1'b0;
        end else begin
            si_len  <= phase_o[1] ? si_len + 32'd1 : '0;
            di_len  <= phase_o[2] ? di_len + 32'd1 : '0;
            zi_len  <= phase_o[3] ? zi_len + 32'd1 : '0;
            frm_len <= (phase_o[1] && !si_seen) ? 32'd1 : frm_len + 32'd1;
            si_seen <= phase_o[1];
        end
    end

    a_r1_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(phase_o) == 1);

    a_r1_order: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(phase_o) && !$past(rst_i)) |->
            phase_o == {$past(phase_o[2:0]), $past(phase_o[3])});

    a_r2_si_len: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(phase_o[1]) && !$past(rst_i)) |-> si_len == 32'(INT_CLKS));

    a_r3_pol_change: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(pol_o) && !$past(rst_i)) |-> ($past(phase_o[1]) && phase_o[2]));

    a_r4_di_len: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(phase_o[2]) && !$past(rst_i) && !ovr_o) |->
            di_len == 32'(result_o) + 32'd1);

    a_r5_ovr_full: assert property (@(posedge clk_i) disable iff (rst_i)
        ovr_o |-> 32'(result_o) == 32'(DI_MAX));

    a_r5_ovr_len: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(phase_o[2]) && !$past(rst_i) && ovr_o) |-> di_len == 32'(DI_MAX));

    a_r6_ovr_change: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(ovr_o) && !$past(rst_i)) |-> ($past(phase_o[2]) && phase_o[3]));

    a_r7_zi_len: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(phase_o[3]) && !$past(rst_i)) |->
            zi_len == (ovr_o ? 32'(ZI_OVR) : 32'(ZI_NORM)));

    a_r8_frame: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o[1] && !si_seen) |-> frm_len == 32'(CYCLE));

    a_r9_busy_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> phase_o[1]);

    a_r9_busy_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(busy_o) && !$past(rst_i)) |-> phase_o[3]);

    a_r10_result_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(result_o) && !$past(rst_i)) |-> ($past(phase_o[2]) && phase_o[3]));
endmodule

bind dsadc_seq dsadc_seq_chk #(
    .INT_CLKS (INT_CLKS),
    .DI_MAX   (DI_MAX),
    .ZI_NORM  (ZI_NORM),
    .ZI_OVR   (ZI_OVR),
    .CYCLE    (CYCLE)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .phase_o  (phase_o),
    .busy_o   (busy_o),
    .pol_o    (pol_o),
    .result_o (result_o),
    .ovr_o    (ovr_o)
);

// File: tb/sim_dsadc_seq.sv
module sim_dsadc_seq;
    localparam int CLK_PERIOD = 10;
    localparam int INT_CLKS   = 20;
    localparam int DI_MAX     = 41;
    localparam int ZI_NORM    = 4;
    localparam int ZI_OVR     = 12;
    localparam int CYCLE      = 100;
    localparam int RW         = $clog2(DI_MAX + 1);

    localparam logic [3:0] SEL_AZ = 4'b0001;
    localparam logic [3:0] SEL_SI = 4'b0010;
    localparam logic [3:0] SEL_DI = 4'b0100;
    localparam logic [3:0] SEL_ZI = 4'b1000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmp = 1'b0;
    logic [3:0]    phase;
    logic          busy, pol, ovr;
    logic [RW-1:0] res;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dsadc_seq #(
        .INT_CLKS (INT_CLKS),
        .DI_MAX   (DI_MAX),
        .ZI_NORM  (ZI_NORM),
        .ZI_OVR   (ZI_OVR),
        .CYCLE    (CYCLE)
    ) u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .cmp_pos_i (cmp),
        .phase_o   (phase),
        .busy_o    (busy),
        .pol_o     (pol),
        .result_o  (res),
        .ovr_o     (ovr)
    );

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    // R11, R8: state after reset and length of the first offset-cancel phase
    task automatic t_reset_start();
        int az = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 phase in reset", int'(phase), int'(SEL_AZ));
        chk("R11 result in reset", int'(res), 0);
        chk("R11 pol in reset", int'(pol), 0);
        chk("R11 ovr in reset", int'(ovr), 0);
        chk("R9 busy in reset", int'(busy), 0);
        rst = 1'b0;
        while (phase == SEL_AZ && az < 4 * CYCLE) begin
            cmp = ~cmp;
            az++;
            @(negedge clk);
        end
        chk("R8 first offset-cancel length", az, CYCLE);
        chk("R1 offset cancel -> integrate", int'(phase), int'(SEL_SI));
    endtask

    // one full frame with input sign p and crossing after k de-integrate clocks
    task automatic t_conv(input logic p, input int k);
        int  si = 0, di = 0, zi = 0, az = 0, bz = 0;
        bit  exp_ovr;
        int  exp_di, exp_res, exp_zi;
        exp_ovr = (k >= DI_MAX);
        exp_di  = exp_ovr ? DI_MAX : k + 1;
        exp_res = exp_ovr ? DI_MAX : k;
        exp_zi  = exp_ovr ? ZI_OVR : ZI_NORM;

        while (phase != SEL_SI) @(negedge clk);
        cmp = p;
        while (phase == SEL_SI) begin
            si++;
            if (busy) bz++;
            @(negedge clk);
        end
        chk("R1 integrate -> de-integrate", int'(phase), int'(SEL_DI));
        chk("R3 latched sign", int'(pol), int'(p));
        chk("R2 integrate length", si, INT_CLKS);
        while (phase == SEL_DI) begin
            if (di == k) cmp = ~p;
            di++;
            if (busy) bz++;
            @(negedge clk);
        end
        chk("R1 de-integrate -> discharge", int'(phase), int'(SEL_ZI));
        chk(exp_ovr ? "R5 de-integrate length" : "R4 de-integrate length", di, exp_di);
        chk(exp_ovr ? "R5 result" : "R4 result", int'(res), exp_res);
        chk("R6 overrange flag", int'(ovr), int'(exp_ovr));
        chk("R9 busy span", bz, INT_CLKS + exp_di);
        while (phase == SEL_ZI) begin
            cmp = ~cmp;
            zi++;
            if (busy) bz++;
            @(negedge clk);
        end
        chk("R1 discharge -> offset cancel", int'(phase), int'(SEL_AZ));
        chk("R7 discharge length", zi, exp_zi);
        while (phase == SEL_AZ) begin
            cmp = ~cmp;
            az++;
            if (busy) bz++;
            @(negedge clk);
        end
        chk("R8 frame length", si + di + zi + az, CYCLE);
        chk("R9 busy low outside conversion", bz, INT_CLKS + exp_di);
        chk("R10 result held", int'(res), exp_res);
        chk("R10 sign held", int'(pol), int'(p));
        chk("R10 overrange held", int'(ovr), int'(exp_ovr));
    endtask

    // R11: reset taken in the middle of de-integration
    task automatic t_reset_mid();
        int az = 0;
        while (phase != SEL_SI) @(negedge clk);
        cmp = 1'b1;
        while (phase != SEL_DI) @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 phase after mid reset", int'(phase), int'(SEL_AZ));
        chk("R11 result after mid reset", int'(res), 0);
        chk("R11 pol after mid reset", int'(pol), 0);
        chk("R11 ovr after mid reset", int'(ovr), 0);
        chk("R11 busy after mid reset", int'(busy), 0);
        rst = 1'b0;
        while (phase == SEL_AZ && az < 4 * CYCLE) begin
            az++;
            @(negedge clk);
        end
        chk("R8 offset cancel after mid reset", az, CYCLE);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!ended) begin
            bad++;
            total++;
            $display("FAIL R8 watchdog act=timeout exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_start();
        t_conv(1'b1, 0);            // R4 crossing on first count
        t_conv(1'b1, 7);            // R4 positive input
        t_conv(1'b0, 15);           // R3 negative input
        t_conv(1'b1, DI_MAX - 1);   // R4 crossing on the last count, no overrange
        t_conv(1'b0, DI_MAX + 50);  // R5 overrange, R7 long discharge
        t_conv(1'b1, 5);            // R6 flag cleared, R7 normal discharge again
        t_conv(1'b1, DI_MAX + 5);   // R5 overrange with positive input
        t_reset_mid();              // R11
        t_conv(1'b0, 3);
        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule